// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This unit forms a 32-bit operand address, or an immediate operand value, from a 3-bit form selector, a base register value, an index register value, a 2-bit scale code and a displacement. The displacement arrives as a 32-bit field. A width flag says whether only its low byte is meaningful, in which case that byte is treated as a signed value and sign-extended. The index is shifted left by the scale code, so it is multiplied by 1, 2, 4 or 8.

A decode stage places a request on the inputs together with a valid pulse. One clock later the unit presents the result, a flag that tells whether the result names a memory location, and a valid strobe. The register file read and the memory access itself are handled by other blocks. All arithmetic wraps modulo 2^32 and no overflow is reported.

Top module: `eff_addr_unit`

## Requirements
- R1: After a synchronous active-high reset, `res_valid`, `res_addr` and `res_is_mem` are all zero.
- R2: `res_valid` is high in exactly the cycle after each cycle in which `req_valid` is high, and it is low in every other cycle.
- R3: When `disp_is_wide` is 0, only bits 7:0 of `disp_field` are used. They are sign-extended to 32 bits, and bits 31:8 of the field have no effect.
- R4: When `disp_is_wide` is 1, all 32 bits of `disp_field` form the signed displacement.
- R5: The index term is `index_val` shifted left by `scale_sel`, giving a factor of 1, 2, 4 or 8 for codes 0 to 3. Only the index is scaled.
- R6: Form code 7 yields base + scaled index + displacement. For example, base 1000, index 40, scale code 2 and displacement 200 give 1360.
- R7: Form code 0 (immediate) returns the extended displacement as the value, with `res_is_mem` = 0.
- R8: Form code 2 (register) returns `base_val` with `res_is_mem` = 0.
- R9: Form code 1 (direct) returns the extended displacement as the address, with `res_is_mem` = 1.
- R10: The remaining codes all set `res_is_mem` = 1. Code 3 yields base. Code 4 yields base + displacement. Code 5 yields scaled index + displacement. Code 6 yields base + scaled index. Any input that a form does not use has no effect on its result.
- R11: Sums wrap modulo 2^32 without any indication.
- R12: In a cycle after `req_valid` was low, `res_addr` and `res_is_mem` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| form_sel | input | 3 | Addressing form code (0 to 7) |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| scale_sel | input | 2 | Index shift amount |
| disp_field | input | 32 | Displacement or immediate bits |
| disp_is_wide | input | 1 | 1: 32-bit displacement, 0: signed low byte |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_addr | output | 32 | Effective address or immediate value |
| res_is_mem | output | 1 | Result names a memory location |

## Verification
The assertions assume that every input is a known value at each clock edge after reset, and that all form codes are legal, because all eight codes are defined. The checks on the hold behaviour and the memory flag read the request only in the cycle where `req_valid` is high. The bench drives inputs on the falling edge and lowers `req_valid` after every single-cycle request. During idle cycles it scrambles the data inputs, so the hold property is exercised against changing values.

// File: rtl/eff_addr_pkg.sv
package eff_addr_pkg;

    localparam int ADDR_W   = 32;
    localparam int NARROW_W = 8;
    localparam int SCALE_W  = 2;
    localparam int FORM_W   = 3;

    typedef enum logic [FORM_W-1:0] {
        F_IMM       = 3'd0,
        F_DIRECT    = 3'd1,
        F_REG       = 3'd2,
        F_REG_IND   = 3'd3,
        F_BASE_DISP = 3'd4,
        F_IDX_DISP  = 3'd5,
        F_BASE_IDX  = 3'd6,
        F_FULL      = 3'd7
    } ea_form_e;

    typedef struct packed {
        logic use_base;
        logic use_index;
        logic use_disp;
        logic is_mem;
    } ea_ctrl_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              is_mem;
    } ea_result_t;

    function automatic ea_ctrl_t decode_form(ea_form_e f);
        ea_ctrl_t c;
        c = '{use_base: 1'b0, use_index: 1'b0, use_disp: 1'b0, is_mem: 1'b1};
        unique case (f)
            F_IMM:       begin c.use_disp = 1'b1; c.is_mem = 1'b0; end
            F_DIRECT:    c.use_disp = 1'b1;
            F_REG:       begin c.use_base = 1'b1; c.is_mem = 1'b0; end
            F_REG_IND:   c.use_base = 1'b1;
            F_BASE_DISP: begin c.use_base = 1'b1; c.use_disp = 1'b1; end
            F_IDX_DISP:  begin c.use_index = 1'b1; c.use_disp = 1'b1; end
            F_BASE_IDX:  begin c.use_base = 1'b1; c.use_index = 1'b1; end
            F_FULL:      begin c.use_base = 1'b1; c.use_index = 1'b1; c.use_disp = 1'b1; end
            default:     c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ea_disp_extend.sv
module ea_disp_extend
    import eff_addr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NW = NARROW_W
) (
    input  logic [AW-1:0] raw,
    input  logic          wide,
    output logic [AW-1:0] ext
);
    localparam int PAD_W = AW - NW;

    always_comb begin
        if (wide) ext = raw;
        else      ext = {{PAD_W{raw[NW-1]}}, raw[NW-1:0]};
    end

    // R3: a narrow displacement has identical upper bits
    always_comb begin
        if (!wide)
            assert (ext[AW-1:NW-1] == '0 || ext[AW-1:NW-1] == '1)
                else $error("p_narrow_sext_r3 violated");
    end
endmodule

// File: rtl/ea_index_scaler.sv
module ea_index_scaler
    import eff_addr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = SCALE_W
) (
    input  logic [AW-1:0] index_in,
    input  logic [SW-1:0] code,
    output logic [AW-1:0] scaled
);
    always_comb scaled = index_in << code;

    // R5: the low code bits of a scaled index are always zero
    always_comb begin
        assert ((scaled & ~({AW{1'b1}} << code)) == '0)
            else $error("p_scale_lowbits_r5 violated");
    end
endmodule

// File: rtl/ea_sum_stage.sv
module ea_sum_stage
    import eff_addr_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  ea_ctrl_t      ctrl,
    input  logic [AW-1:0] base_v,
    input  logic [AW-1:0] scaled_v,
    input  logic [AW-1:0] disp_v,
    output ea_result_t    result,
    output logic          strobe
);
    logic [AW-1:0] t_base, t_idx, t_disp, sum;

    always_comb begin
        t_base = ctrl.use_base  ? base_v   : '0;
        t_idx  = ctrl.use_index ? scaled_v : '0;
        t_disp = ctrl.use_disp  ? disp_v   : '0;
        sum    = t_base + t_idx + t_disp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= load;
            if (load) begin
                result.addr   <= sum;
                result.is_mem <= ctrl.is_mem;
            end
        end
    end

    // R12: an idle cycle leaves the held result untouched
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(result));
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
    import eff_addr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NW = NARROW_W,
    parameter int SW = SCALE_W,
    parameter int FW = FORM_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [FW-1:0] form_sel,
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] index_val,
    input  logic [SW-1:0] scale_sel,
    input  logic [AW-1:0] disp_field,
    input  logic          disp_is_wide,
    output logic          res_valid,
    output logic [AW-1:0] res_addr,
    output logic          res_is_mem
);
    logic [AW-1:0] disp_ext, idx_scaled;
    ea_ctrl_t      ctrl;
    ea_result_t    res;

    always_comb ctrl = decode_form(ea_form_e'(form_sel));

    ea_disp_extend #(.AW(AW), .NW(NW)) u_ext (
        .raw(disp_field), .wide(disp_is_wide), .ext(disp_ext));

    ea_index_scaler #(.AW(AW), .SW(SW)) u_scale (
        .index_in(index_val), .code(scale_sel), .scaled(idx_scaled));

    ea_sum_stage #(.AW(AW)) u_sum (
        .clk(clk), .rst(rst), .load(req_valid), .ctrl(ctrl),
        .base_v(base_val), .scaled_v(idx_scaled), .disp_v(disp_ext),
        .result(res), .strobe(res_valid));

    assign res_addr   = res.addr;
    assign res_is_mem = res.is_mem;

    // R2: strobe follows the request by exactly one cycle
    p_strobe_follow_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);
    p_strobe_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid);
    // R7 / R8: immediate and register forms flag no memory access
    p_nomem_forms_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (form_sel == F_IMM || form_sel == F_REG)) |=> !res_is_mem);
    // R9 / R10: every other form flags a memory access
    p_mem_forms_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && form_sel != F_IMM && form_sel != F_REG) |=> res_is_mem);
    // R8: register form passes the base through
    p_reg_pass_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && form_sel == F_REG) |=> res_addr == $past(base_val));
endmodule

// File: tb/eff_addr_unit_bench.sv
module eff_addr_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  form_sel;
    logic [31:0] base_val, index_val, disp_field;
    logic [1:0]  scale_sel;
    logic        disp_is_wide;
    logic        res_valid, res_is_mem;
    logic [31:0] res_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    eff_addr_unit u_eff_addr_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .form_sel(form_sel),
        .base_val(base_val), .index_val(index_val), .scale_sel(scale_sel),
        .disp_field(disp_field), .disp_is_wide(disp_is_wide),
        .res_valid(res_valid), .res_addr(res_addr), .res_is_mem(res_is_mem));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_addr(logic [2:0] f, logic [31:0] b,
            logic [31:0] x, logic [1:0] s, logic [31:0] d, logic w);
        logic [31:0] dx, xs;
        dx = w ? d : {{24{d[7]}}, d[7:0]};
        case (s)
            2'd0: xs = x;
            2'd1: xs = x * 2;
            2'd2: xs = x * 4;
            default: xs = x * 8;
        endcase
        case (f)
            3'd0, 3'd1: return dx;
            3'd2, 3'd3: return b;
            3'd4: return b + dx;
            3'd5: return xs + dx;
            3'd6: return b + xs;
            default: return b + xs + dx;
        endcase
    endfunction

    task automatic run_req(string req, logic [2:0] f, logic [31:0] b,
            logic [31:0] x, logic [1:0] s, logic [31:0] d, logic w);
        @(negedge clk);
        req_valid = 1'b1; form_sel = f; base_val = b; index_val = x;
        scale_sel = s; disp_field = d; disp_is_wide = w;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req, {31'd0, res_valid}, 32'd1);
        chk(req, res_addr, model_addr(f, b, x, s, d, w));
        chk(req, {31'd0, res_is_mem}, {31'd0, (f != 3'd0 && f != 3'd2)});
    endtask

    task automatic t_reset();
        rst = 1'b1; req_valid = 1'b0; form_sel = '0; base_val = '0;
        index_val = '0; scale_sel = '0; disp_field = '0; disp_is_wide = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 valid", {31'd0, res_valid}, 32'd0);
        chk("R1 addr", res_addr, 32'd0);
        chk("R1 mem", {31'd0, res_is_mem}, 32'd0);
    endtask

    task automatic t_full_example();
        run_req("R6", 3'd7, 32'd1000, 32'd40, 2'd2, 32'd200, 1'b1);
        chk("R6 literal", res_addr, 32'd1360);
    endtask

    task automatic t_scales();
        for (int s = 0; s < 4; s++)
            run_req("R5", 3'd6, 32'h100, 32'h3, 2'(s), 32'h0, 1'b1);
    endtask

    task automatic t_narrow_disp();
        run_req("R3 neg", 3'd4, 32'd500, 32'd0, 2'd0, 32'hABCD_12F0, 1'b0);
        chk("R3 value", res_addr, 32'd484);
        run_req("R3 pos", 3'd4, 32'd500, 32'd0, 2'd0, 32'hFFFF_FF7F, 1'b0);
        chk("R3 value", res_addr, 32'd627);
    endtask

    task automatic t_wide_disp();
        run_req("R4", 3'd4, 32'h1000, 32'd0, 2'd0, 32'hFFFF_F000, 1'b1);
        chk("R4 value", res_addr, 32'h0);
    endtask

    task automatic t_immediate();
        run_req("R7", 3'd0, 32'h5555, 32'h7777, 2'd3, 32'h0003_FA00, 1'b1);
        run_req("R7 narrow", 3'd0, 32'h5555, 32'h7777, 2'd1, 32'h19, 1'b0);
    endtask

    task automatic t_register();
        run_req("R8", 3'd2, 32'hDEAD_BEEF, 32'h1234, 2'd3, 32'h99, 1'b1);
    endtask

    task automatic t_direct();
        run_req("R9", 3'd1, 32'hAAAA, 32'hBBBB, 2'd2, 32'h0001_2340, 1'b1);
    endtask

    task automatic t_other_forms();
        run_req("R10 ind", 3'd3, 32'h2000, 32'h55, 2'd3, 32'h77, 1'b1);
        run_req("R10 bd", 3'd4, 32'h2000, 32'h55, 2'd3, 32'h77, 1'b1);
        run_req("R10 xd", 3'd5, 32'h2000, 32'h55, 2'd3, 32'h77, 1'b1);
        run_req("R10 bx", 3'd6, 32'h2000, 32'h55, 2'd3, 32'h77, 1'b1);
    endtask

    task automatic t_wrap();
        run_req("R11", 3'd4, 32'hFFFF_FFF0, 32'd0, 2'd0, 32'h20, 1'b1);
        chk("R11 value", res_addr, 32'h10);
        run_req("R11 idx", 3'd7, 32'h8000_0000, 32'h4000_0000, 2'd1, 32'h1, 1'b1);
        chk("R11 value", res_addr, 32'h1);
    endtask

    task automatic t_idle_hold();
        logic [31:0] held;
        run_req("R2", 3'd5, 32'd0, 32'd9, 2'd1, 32'd2, 1'b0);
        held = res_addr;
        form_sel = 3'd2; base_val = 32'hCAFE_0000;
        @(negedge clk);
        chk("R2 strobe low", {31'd0, res_valid}, 32'd0);
        chk("R12 addr held", res_addr, held);
        chk("R12 mem held", {31'd0, res_is_mem}, 32'd1);
    endtask

    initial begin
        t_reset();
        t_full_example();
        t_scales();
        t_narrow_disp();
        t_wide_disp();
        t_immediate();
        t_register();
        t_direct();
        t_other_forms();
        t_wrap();
        t_idle_hold();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule